// File: doc/BRIEF.md
# Byte-Serial Stack Processor

This block is a small multi-cycle processor that owns no general-purpose registers. Every arithmetic operand sits in a dedicated 256-byte stack memory. A stack-pointer register tracks that memory. The stack fills from location 0 toward higher locations, and an empty stack is shown by a pointer of all ones. Code and data share a second memory, one byte wide. It is reached through a 16-bit byte address, and the array holds the low `MEM_AW` address bits, so higher addresses alias onto it. Each memory access, to either memory, takes one clock cycle.

Instructions are one or three bytes long and packed back to back. The controller reads them one byte per cycle: first the opcode, then, when the instruction carries one, a 16-bit operand address with its high byte first. The four operations are:

- load a byte from memory onto the stack;
- store the top of the stack to memory;
- replace the top two entries with their sum;
- pop two entries and branch when they are equal.

While `run` is low the processor is frozen, and a host port reads and writes the code/data memory. This port is used to load programs and to collect results. Any unrecognised opcode stops the processor for good.

Top module: `stack_cpu`

## Requirements
- R1: After reset, `pc_o` is 0x0000, `sp_o` is 0xFF (empty stack) and `halted` is low.
- R2: Opcode 0x00 followed by address bytes H, L (address H*256+L) increments SP and then writes memory[address] into stack[SP]. PC advances by 3, and the instruction occupies 5 clock cycles.
- R3: Opcode 0x01 followed by H, L writes stack[SP] into memory[H*256+L] and then decrements SP. PC advances by 3, and the instruction occupies 5 clock cycles.
- R4: Opcode 0x02 is a single byte. It pops two entries and pushes their sum modulo 256, so SP drops by one and PC advances by 1.
- R5: Opcode 0x04 followed by H, L pops two entries (SP drops by two). When they are equal, the next opcode is fetched from H*256+L.
- R6: When the two entries popped by opcode 0x04 differ, execution continues at the byte after the instruction (PC advances by 3).
- R7: Any opcode other than 0x00, 0x01, 0x02 or 0x04 raises `halted`. After that, `halted` stays high and `pc_o` (one past the bad opcode) and `sp_o` no longer change.
- R8: While `run` is low, the processor makes no progress. `pc_o` and `sp_o` hold their values, and an instruction interrupted part way completes correctly once `run` returns high.
- R9: While `run` is low, a host strobe with `host_we` high writes `host_wdata` to the addressed byte. A strobe with `host_we` low returns that byte on `host_rdata` one cycle later.
- R10: The stack is last-in first-out. The first push from an empty stack uses stack location 0, and three pushes leave SP at 0x02.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | High lets the processor execute; low freezes it and hands memory to the host |
| host_en | input | 1 | Host access strobe, honoured only while `run` is low |
| host_we | input | 1 | Host write when high, read when low |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after a read strobe |
| halted | output | 1 | Processor stopped on an unknown opcode |
| pc_o | output | 16 | Program counter |
| sp_o | output | 8 | Stack pointer |

## Verification
The bench targets the points where a byte-serial stack machine usually goes wrong.

- **Operand order.** It pushes three values and stores them back. A pointer that post-increments, or a store that moves SP before reading, would return the values in the wrong places.
- **Sum width.** It adds 0xF0 and 0x25. A design that kept the carry or dropped the first popped operand would not leave 0x15.
- **Branch direction.** It runs the conditional branch both taken and not taken. An inverted compare, or a PC update in the wrong state, would end at the wrong halt address.
- **Timing and freezing.** It counts the cycles of a load/store pair, and it freezes the machine mid-instruction. A design that lost its pending read while paused would store a wrong byte.

// File: rtl/stack_cpu_pkg.sv
// Shared opcode and controller state encodings for the stack processor.
// Assumes 8-bit opcodes; the numeric values are the instruction encoding.
package stack_cpu_pkg;

    typedef enum logic [7:0] {
        OP_LOAD  = 8'h00,
        OP_STORE = 8'h01,
        OP_SUM   = 8'h02,
        OP_BREQ  = 8'h04
    } opcode_e;

    typedef enum logic [3:0] {
        S_FETCH,
        S_DECODE,
        S_ADR_HI,
        S_ADR_LO,
        S_LOAD_WR,
        S_STORE_WR,
        S_SUM_A,
        S_SUM_B,
        S_BR_A,
        S_BR_B,
        S_STOP
    } ctl_state_e;

endpackage

// File: rtl/byte_ram.sv
// Single-port synchronous byte memory with a registered read port.
// Assumes one access per cycle; rdata changes only on an enabled read.
module byte_ram #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    // Perform the enabled write or registered read.
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) cells[addr] <= wdata;
            else    rdata       <= cells[addr];
        end
    end

endmodule

// File: rtl/stack_cpu_ctrl.sv
// Fetch/decode/execute controller of the stack processor.
// Drives one access per cycle to each memory and consumes registered read
// data one cycle after the request. Holds all state while run is low.
module stack_cpu_ctrl
    import stack_cpu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              stk_en,
    output logic              stk_we,
    output logic [SP_W-1:0]   stk_addr,
    output logic [7:0]        stk_wdata,
    input  logic [7:0]        stk_rdata,
    output logic [ADDR_W-1:0] pc,
    output logic [SP_W-1:0]   sp,
    output logic              halted,
    output ctl_state_e        state
);
    localparam logic [SP_W-1:0]   SP_ONE = SP_W'(1);
    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    ctl_state_e        state_q;
    logic [ADDR_W-1:0] pc_q;
    logic [SP_W-1:0]   sp_q;
    logic [7:0]        ir_q;
    logic [7:0]        ahi_q;
    logic [ADDR_W-1:0] opa_q;
    logic [7:0]        tmp_q;
    logic              m_en, s_en;

    // Decide which memory access the current state issues.
    always_comb begin
        m_en      = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = pc_q;
        mem_wdata = stk_rdata;
        s_en      = 1'b0;
        stk_we    = 1'b0;
        stk_addr  = sp_q;
        stk_wdata = mem_rdata;
        unique case (state_q)
            S_FETCH:  m_en = 1'b1;
            S_DECODE: begin
                case (mem_rdata)
                    OP_SUM:                     s_en = 1'b1;
                    OP_LOAD, OP_STORE, OP_BREQ: m_en = 1'b1;
                    default: ;
                endcase
            end
            S_ADR_HI: m_en = 1'b1;
            S_ADR_LO: begin
                if (ir_q == OP_LOAD) begin
                    m_en     = 1'b1;
                    mem_addr = {ahi_q, mem_rdata};
                end else begin
                    s_en = 1'b1;
                end
            end
            S_LOAD_WR: begin
                s_en     = 1'b1;
                stk_we   = 1'b1;
                stk_addr = sp_q + SP_ONE;
            end
            S_STORE_WR: begin
                m_en     = 1'b1;
                mem_we   = 1'b1;
                mem_addr = opa_q;
            end
            S_SUM_A, S_BR_A: begin
                s_en     = 1'b1;
                stk_addr = sp_q - SP_ONE;
            end
            S_SUM_B: begin
                s_en      = 1'b1;
                stk_we    = 1'b1;
                stk_wdata = tmp_q + stk_rdata;
            end
            default: ;
        endcase
        mem_en = m_en & run;
        stk_en = s_en & run;
    end

    // Advance the controller state and architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_FETCH;
            pc_q    <= '0;
            sp_q    <= '1;
            ir_q    <= '0;
            ahi_q   <= '0;
            opa_q   <= '0;
            tmp_q   <= '0;
        end else if (run) begin
            unique case (state_q)
                S_FETCH: begin
                    pc_q    <= pc_q + PC_ONE;
                    state_q <= S_DECODE;
                end
                S_DECODE: begin
                    ir_q <= mem_rdata;
                    case (mem_rdata)
                        OP_SUM: state_q <= S_SUM_A;
                        OP_LOAD, OP_STORE, OP_BREQ: begin
                            pc_q    <= pc_q + PC_ONE;
                            state_q <= S_ADR_HI;
                        end
                        default: state_q <= S_STOP;
                    endcase
                end
                S_ADR_HI: begin
                    ahi_q   <= mem_rdata;
                    pc_q    <= pc_q + PC_ONE;
                    state_q <= S_ADR_LO;
                end
                S_ADR_LO: begin
                    opa_q <= {ahi_q, mem_rdata};
                    case (ir_q)
                        OP_LOAD:  state_q <= S_LOAD_WR;
                        OP_STORE: state_q <= S_STORE_WR;
                        default:  state_q <= S_BR_A;
                    endcase
                end
                S_LOAD_WR: begin
                    sp_q    <= sp_q + SP_ONE;
                    state_q <= S_FETCH;
                end
                S_STORE_WR: begin
                    sp_q    <= sp_q - SP_ONE;
                    state_q <= S_FETCH;
                end
                S_SUM_A: begin
                    tmp_q   <= stk_rdata;
                    sp_q    <= sp_q - SP_ONE;
                    state_q <= S_SUM_B;
                end
                S_SUM_B: state_q <= S_FETCH;
                S_BR_A: begin
                    tmp_q   <= stk_rdata;
                    sp_q    <= sp_q - SP_ONE;
                    state_q <= S_BR_B;
                end
                S_BR_B: begin
                    sp_q <= sp_q - SP_ONE;
                    if (tmp_q == stk_rdata) pc_q <= opa_q;
                    state_q <= S_FETCH;
                end
                default: state_q <= S_STOP;
            endcase
        end
    end

    assign pc     = pc_q;
    assign sp     = sp_q;
    assign halted = (state_q == S_STOP);
    assign state  = state_q;

endmodule

// File: rtl/stack_cpu.sv
// Stack processor top: controller, code/data memory and stack memory.
// The code/data array keeps the low MEM_AW address bits (higher bits alias).
// The host port owns the code/data memory while run is low.
module stack_cpu
    import stack_cpu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MEM_AW = 12,
    parameter int SP_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              host_en,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              halted,
    output logic [ADDR_W-1:0] pc_o,
    output logic [SP_W-1:0]   sp_o
);
    logic              c_mem_en, c_mem_we;
    logic [ADDR_W-1:0] c_mem_addr;
    logic [7:0]        c_mem_wdata;
    logic              stk_en, stk_we;
    logic [SP_W-1:0]   stk_addr;
    logic [7:0]        stk_wdata, stk_rdata;
    logic              m_en, m_we;
    logic [ADDR_W-1:0] m_addr;
    logic [7:0]        m_wdata, m_rdata;
    ctl_state_e        ctl_state_unused;

    stack_cpu_ctrl #(.ADDR_W(ADDR_W), .SP_W(SP_W)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .mem_en   (c_mem_en),
        .mem_we   (c_mem_we),
        .mem_addr (c_mem_addr),
        .mem_wdata(c_mem_wdata),
        .mem_rdata(m_rdata),
        .stk_en   (stk_en),
        .stk_we   (stk_we),
        .stk_addr (stk_addr),
        .stk_wdata(stk_wdata),
        .stk_rdata(stk_rdata),
        .pc       (pc_o),
        .sp       (sp_o),
        .halted   (halted),
        .state    (ctl_state_unused)
    );

    // Give the code/data port to the processor or to the host.
    always_comb begin
        if (run) begin
            m_en    = c_mem_en;
            m_we    = c_mem_we;
            m_addr  = c_mem_addr;
            m_wdata = c_mem_wdata;
        end else begin
            m_en    = host_en;
            m_we    = host_we;
            m_addr  = host_addr;
            m_wdata = host_wdata;
        end
    end

    generate
        if (MEM_AW < ADDR_W) begin : g_alias
            logic unused_hi;
            assign unused_hi = ^m_addr[ADDR_W-1:MEM_AW];
        end
    endgenerate

    byte_ram #(.AW(MEM_AW)) u_code (
        .clk  (clk),
        .en   (m_en),
        .we   (m_we),
        .addr (m_addr[MEM_AW-1:0]),
        .wdata(m_wdata),
        .rdata(m_rdata)
    );

    byte_ram #(.AW(SP_W)) u_stack (
        .clk  (clk),
        .en   (stk_en),
        .we   (stk_we),
        .addr (stk_addr),
        .wdata(stk_wdata),
        .rdata(stk_rdata)
    );

    assign host_rdata = m_rdata;

endmodule

// File: rtl/stack_cpu_chk.sv
// Property checker for the stack processor, bound onto the top module.
// Observes ports plus the controller state tap; drives nothing.
module stack_cpu_chk
    import stack_cpu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SP_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              halted,
    input logic [ADDR_W-1:0] pc,
    input logic [SP_W-1:0]   sp,
    input ctl_state_e        st
);
    // R7: once stopped, everything stays put.
    a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(sp)));

    // R7: stopping only follows the decode of an opcode.
    a_r7_halt_from_decode: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> ($past(st) == S_DECODE));

    // R8: a frozen processor holds PC and SP.
    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !halted) |=> ($stable(pc) && $stable(sp)));

    // R10: SP moves by exactly one step at a time.
    a_r10_sp_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sp != $past(sp)) |-> ((sp == $past(sp) + SP_W'(1)) || (sp == $past(sp) - SP_W'(1))));

    // R5: PC leaves its sequential path only when a branch resolves.
    a_r5_jump_only_on_branch: assert property (@(posedge clk) disable iff (!rst_n)
        ((pc != $past(pc)) && (pc != $past(pc) + ADDR_W'(1))) |-> ($past(st) == S_BR_B));

endmodule

bind stack_cpu stack_cpu_chk #(.ADDR_W(ADDR_W), .SP_W(SP_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .halted(halted),
    .pc    (pc_o),
    .sp    (sp_o),
    .st    (ctl_state_unused)
);

// File: tb/stack_cpu_tb.sv
// Directed bench for the stack processor: one task per scenario.
module stack_cpu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        host_en = 1'b0;
    logic        host_we = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        halted;
    logic [15:0] pc_o;
    logic [7:0]  sp_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    stack_cpu u_dut (
        .clk(clk), .rst_n(rst_n), .run(run),
        .host_en(host_en), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .halted(halted), .pc_o(pc_o), .sp_o(sp_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_en = 1'b0; host_we = 1'b0;
    endtask

    task automatic peek(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        host_en = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        host_en = 1'b0;
        d = host_rdata;
    endtask

    task automatic instr(input logic [15:0] at, input logic [7:0] op, input logic [15:0] a);
        poke(at, op);
        poke(at + 16'd1, a[15:8]);
        poke(at + 16'd2, a[7:0]);
    endtask

    task automatic hold_reset();
        @(negedge clk);
        run = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Release reset, run until halted; returns the cycle count.
    task automatic go(output int cycles);
        @(negedge clk);
        rst_n = 1'b1;
        run = 1'b1;
        cycles = 0;
        while (!halted && cycles < 2000) begin
            @(negedge clk);
            cycles++;
        end
        run = 1'b0;
        if (!halted) begin
            n_tests++; n_fail++;
            $display("FAIL R7: processor never halted, actual 0 expected 1");
        end
    endtask

    task automatic t_reset();
        hold_reset();
        check("R1 pc", pc_o, 16'h0000);
        check("R1 sp", sp_o, 8'hFF);
        check("R1 halted", halted, 0);
    endtask

    task automatic t_host();
        logic [7:0] d;
        poke(16'h0300, 8'hC3);
        poke(16'h0301, 8'h3C);
        peek(16'h0300, d); check("R9 read 300", d, 8'hC3);
        peek(16'h0301, d); check("R9 read 301", d, 8'h3C);
    endtask

    task automatic t_load_store();
        int cyc; logic [7:0] d;
        hold_reset();
        poke(16'h0100, 8'h5A);
        instr(16'h0000, 8'h00, 16'h0100);
        instr(16'h0003, 8'h01, 16'h0200);
        poke(16'h0006, 8'hFF);
        go(cyc);
        check("R2 R3 cycles (5+5+2)", cyc, 12);
        peek(16'h0200, d); check("R3 stored byte", d, 8'h5A);
        check("R3 sp back to empty", sp_o, 8'hFF);
        check("R7 pc after bad opcode", pc_o, 16'h0007);
    endtask

    task automatic t_sum();
        int cyc; logic [7:0] d;
        hold_reset();
        poke(16'h0100, 8'hF0);
        poke(16'h0101, 8'h25);
        instr(16'h0000, 8'h00, 16'h0100);
        instr(16'h0003, 8'h00, 16'h0101);
        poke(16'h0006, 8'h02);
        instr(16'h0007, 8'h01, 16'h0200);
        poke(16'h000A, 8'hFF);
        go(cyc);
        peek(16'h0200, d); check("R4 sum mod 256", d, 8'h15);
        check("R4 sp", sp_o, 8'hFF);
        check("R4 one-byte opcode pc", pc_o, 16'h000B);
    endtask

    task automatic t_branch(input logic [7:0] b, input bit taken);
        int cyc; logic [7:0] d;
        hold_reset();
        poke(16'h0100, 8'h07);
        poke(16'h0101, b);
        poke(16'h0200, 8'hAA);
        instr(16'h0000, 8'h00, 16'h0100);
        instr(16'h0003, 8'h00, 16'h0101);
        instr(16'h0006, 8'h04, 16'h0020);
        poke(16'h0009, 8'hFF);
        instr(16'h0020, 8'h00, 16'h0100);
        instr(16'h0023, 8'h01, 16'h0200);
        poke(16'h0026, 8'hFE);
        go(cyc);
        peek(16'h0200, d);
        if (taken) begin
            check("R5 taken pc", pc_o, 16'h0027);
            check("R5 target code ran", d, 8'h07);
            check("R5 sp", sp_o, 8'hFF);
        end else begin
            check("R6 fallthrough pc", pc_o, 16'h000A);
            check("R6 target code skipped", d, 8'hAA);
            check("R6 sp", sp_o, 8'hFF);
        end
    endtask

    task automatic t_lifo();
        int cyc; logic [7:0] d;
        hold_reset();
        poke(16'h0100, 8'h11); poke(16'h0101, 8'h22); poke(16'h0102, 8'h33);
        instr(16'h0000, 8'h00, 16'h0100);
        instr(16'h0003, 8'h00, 16'h0101);
        instr(16'h0006, 8'h00, 16'h0102);
        poke(16'h0009, 8'h03);
        go(cyc);
        check("R10 sp after three pushes", sp_o, 8'h02);
        check("R7 pc after opcode 0x03", pc_o, 16'h000A);
        hold_reset();
        poke(16'h0009, 8'h00); poke(16'h000A, 8'h00); poke(16'h000B, 8'h00);
        instr(16'h0009, 8'h01, 16'h0200);
        instr(16'h000C, 8'h01, 16'h0201);
        instr(16'h000F, 8'h01, 16'h0202);
        poke(16'h0012, 8'hFF);
        go(cyc);
        peek(16'h0200, d); check("R10 first pop is last push", d, 8'h33);
        peek(16'h0201, d); check("R10 second pop", d, 8'h22);
        peek(16'h0202, d); check("R10 third pop is first push", d, 8'h11);
    endtask

    task automatic t_halt_hold();
        logic [15:0] p; logic [7:0] s;
        @(negedge clk);
        run = 1'b1;
        p = pc_o; s = sp_o;
        repeat (5) @(negedge clk);
        check("R7 still halted", halted, 1);
        check("R7 pc frozen", pc_o, p);
        check("R7 sp frozen", sp_o, s);
        run = 1'b0;
    endtask

    task automatic t_freeze();
        int cyc; logic [7:0] d; logic [15:0] p; logic [7:0] s;
        hold_reset();
        poke(16'h0100, 8'h9C);
        poke(16'h0200, 8'h00);
        instr(16'h0000, 8'h00, 16'h0100);
        instr(16'h0003, 8'h01, 16'h0200);
        poke(16'h0006, 8'hFF);
        @(negedge clk);
        rst_n = 1'b1; run = 1'b1;
        repeat (4) @(negedge clk);
        run = 1'b0;
        p = pc_o; s = sp_o;
        repeat (4) @(negedge clk);
        check("R8 pc held", pc_o, p);
        check("R8 sp held", sp_o, s);
        cyc = 0;
        run = 1'b1;
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        run = 1'b0;
        peek(16'h0200, d); check("R8 resumed result", d, 8'h9C);
    endtask

    initial begin
        t_reset();
        t_host();
        t_load_store();
        t_halt_hold();
        t_sum();
        t_branch(8'h07, 1'b1);
        t_branch(8'h08, 1'b0);
        t_lifo();
        t_freeze();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule